// File: doc/BRIEF.md
# Lighting-bus forward-frame address filter and command gate

This block sits directly after the receiver of a two-wire lighting control bus. Each decoded 16-bit forward frame arrives with a one-cycle strobe. The block decides whether this slave must act on the frame. It reads the upper byte as the address and sorts it into one of five classes: a single-device (short) address, a group address, a broadcast, a special command, or a reserved code.

For addressed frames it compares the address with the slave's programmed short address and with its 16-bit group membership mask. It then uses the lowest address bit (the selector) to tell a direct brightness level from a numbered command. Special commands are taken by every slave, whatever its addresses.

Configuration commands are numbered 32 to 128. Such a command is only passed on when the identical frame has come in twice, and the second copy must arrive before a window of `WINDOW_MS` millisecond ticks has expired. The block emits an accept pulse together with the data byte, the frame kind and, for special commands, a 5-bit special index. It does not execute the commands.

Top module: `dali_cmd_gate`

## Requirements
- R1: An address byte with bit 7 = 0 is a short address; bits 6..1 give the address 0..63. The frame is accepted only when `own_short` equals that number (upper two bits of `own_short` zero). Any `own_short` above 63, such as 8'hFF for an unprogrammed slave, matches no short address but does not block broadcast or group frames.
- R2: An address byte 100GGGGS is group GGGG (bits 4..1). The frame is accepted when bit GGGG of `group_mask` is 1.
- R3: The address bytes 8'hFE and 8'hFF (1111111S) are broadcasts and are accepted by every slave.
- R4: The address bytes 101CCCC1 and 110CCCC1 are special commands. They are accepted regardless of the slave's addresses, with `acc_kind` = 2, `acc_spc` = {bit 6, bits 4..1} and `acc_data` = the second byte. These same patterns with bit 0 = 0, and all other address bytes that start with 111 and are not broadcasts, are reserved and never accepted.
- R5: For short, group and broadcast frames, selector bit 0 = 0 gives `acc_kind` = 0 (direct level) and bit 0 = 1 gives `acc_kind` = 1 (command). In both cases `acc_data` carries the second byte.
- R6: `acc_valid` rises exactly one clock after an accepted `frame_valid` cycle and lasts one cycle. Without `frame_valid` it stays low.
- R7: A command frame addressed to this slave with a command number from 32 to 128 is not accepted on its first arrival. An identical frame received next, within the window, is accepted. A configuration frame addressed to another slave is never accepted.
- R8: The window closes once `WINDOW_MS` `ms_tick` pulses have passed since the first copy. A copy arriving after that is treated as a new first copy and is not accepted.
- R9: Any different frame that arrives between the two copies cancels the pending one, so the next copy is again a first copy.
- R10: Command numbers 0..31 and 129..255, and all direct levels, are accepted on their first arrival.
- R11: Reset drives `acc_valid` low and discards any pending configuration frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: a new forward frame is on `frame` |
| frame | input | 16 | Address byte (15..8) and data byte (7..0) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| own_short | input | 8 | Programmed short address; values above 63 mean none |
| group_mask | input | 16 | Group membership, bit n = group n |
| acc_valid | output | 1 | Accept pulse |
| acc_data | output | 8 | Level or command byte of the accepted frame |
| acc_kind | output | 2 | 0 level, 1 command, 2 special |
| acc_spc | output | 5 | Special command index (valid when kind is 2) |

## Verification
Every result is due one clock after the `frame_valid` cycle, because each output is held in one register stage. The bench therefore drives a frame on a falling edge, drops the strobe at the next falling edge and reads all four outputs there, one rising edge later. For the repeat window, the state after the window ticks only affects the verdict on the next frame. Ticks are sent as separate one-cycle pulses that never share a cycle with a frame. The verdict is then read at the same single-cycle offset after the following copy.

// File: rtl/dali_gate_pkg.sv
package dali_gate_pkg;

    localparam int unsigned FRAME_W = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned SPC_W   = 5;

    typedef enum logic [1:0] {
        KIND_ARC = 2'd0,
        KIND_CMD = 2'd1,
        KIND_SPC = 2'd2
    } kind_e;

    typedef struct packed {
        logic              hit;
        logic              is_cfg;
        kind_e             kind;
        logic [SPC_W-1:0]  spc;
    } decode_t;

endpackage

// File: rtl/dali_addr_decode.sv
module dali_addr_decode
    import dali_gate_pkg::*;
#(
    parameter int unsigned GROUPS    = 16,
    parameter int unsigned CFG_FIRST = 32,
    parameter int unsigned CFG_LAST  = 128
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [7:0]         own_short,
    input  logic [GROUPS-1:0]  group_mask,
    output decode_t            dec
);
    localparam int unsigned GSEL_W = $clog2(GROUPS);

    logic [BYTE_W-1:0] addr_b;
    logic [BYTE_W-1:0] data_b;
    logic              sel;
    logic              is_short, is_group, is_bcast, is_spc;
    logic              short_hit, group_hit;

    always_comb begin
        addr_b    = frame[FRAME_W-1:BYTE_W];
        data_b    = frame[BYTE_W-1:0];
        sel       = addr_b[0];
        is_short  = (addr_b[7] == 1'b0);
        is_group  = (addr_b[7:5] == 3'b100);
        is_bcast  = (addr_b[7:1] == 7'h7F);
        is_spc    = ((addr_b[7:5] == 3'b101) || (addr_b[7:5] == 3'b110)) && sel;
        short_hit = is_short && (own_short == {2'b00, addr_b[6:1]});
        group_hit = is_group && group_mask[addr_b[GSEL_W:1]];

        dec.hit    = short_hit || group_hit || is_bcast || is_spc;
        dec.kind   = is_spc ? KIND_SPC : (sel ? KIND_CMD : KIND_ARC);
        dec.spc    = is_spc ? {addr_b[6], addr_b[4:1]} : '0;
        dec.is_cfg = !is_spc && sel &&
                     (int'(data_b) >= int'(CFG_FIRST)) &&
                     (int'(data_b) <= int'(CFG_LAST));
    end

endmodule

// File: rtl/dali_repeat_qual.sv
module dali_repeat_qual
    import dali_gate_pkg::*;
#(
    parameter int unsigned WINDOW_MS = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame,
    input  logic               hit,
    input  logic               is_cfg,
    input  logic               ms_tick,
    output logic               pass
);
    localparam int unsigned CNT_W = $clog2(WINDOW_MS + 1);

    typedef struct packed {
        logic               armed;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] held;
    } rq_t;

    rq_t  st_d, st_q;
    logic twin;

    always_comb begin
        st_d = st_q;
        twin = st_q.armed && (st_q.held == frame);
        pass = !is_cfg || twin;

        if (ms_tick && st_q.armed) begin
            if (st_q.cnt == CNT_W'(WINDOW_MS - 1)) begin
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (frame_valid) begin
            if (hit && is_cfg && !twin) begin
                st_d.armed = 1'b1;
                st_d.held  = frame;
                st_d.cnt   = '0;
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dali_cmd_gate.sv
module dali_cmd_gate
    import dali_gate_pkg::*;
#(
    parameter int unsigned WINDOW_MS = 100,
    parameter int unsigned GROUPS    = 16,
    parameter int unsigned CFG_FIRST = 32,
    parameter int unsigned CFG_LAST  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [15:0]        frame,
    input  logic               ms_tick,
    input  logic [7:0]         own_short,
    input  logic [GROUPS-1:0]  group_mask,
    output logic               acc_valid,
    output logic [7:0]         acc_data,
    output logic [1:0]         acc_kind,
    output logic [4:0]         acc_spc
);
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        kind_e             kind;
        logic [SPC_W-1:0]  spc;
    } out_t;

    decode_t dec;
    logic    pass;
    out_t    out_d, out_q;

    dali_addr_decode #(
        .GROUPS    (GROUPS),
        .CFG_FIRST (CFG_FIRST),
        .CFG_LAST  (CFG_LAST)
    ) u_dec (
        .frame      (frame),
        .own_short  (own_short),
        .group_mask (group_mask),
        .dec        (dec)
    );

    dali_repeat_qual #(
        .WINDOW_MS (WINDOW_MS)
    ) u_rep (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame       (frame),
        .hit         (dec.hit),
        .is_cfg      (dec.is_cfg),
        .ms_tick     (ms_tick),
        .pass        (pass)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = frame_valid && dec.hit && pass;
        if (frame_valid && dec.hit && pass) begin
            out_d.data = frame[BYTE_W-1:0];
            out_d.kind = dec.kind;
            out_d.spc  = dec.spc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign acc_valid = out_q.valid;
    assign acc_data  = out_q.data;
    assign acc_kind  = out_q.kind;
    assign acc_spc   = out_q.spc;

endmodule

// File: rtl/dali_cmd_gate_chk.sv
module dali_cmd_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_valid,
    input logic [15:0] frame,
    input logic [7:0]  own_short,
    input logic        acc_valid,
    input logic [1:0]  acc_kind,
    input logic [4:0]  acc_spc
);
    // R6: an accept always follows a frame strobe one cycle earlier
    p_acc_needs_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(frame_valid));

    // R5: the selector bit of a non-special frame sets the kind
    p_kind_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 2'd2) |-> (acc_kind[0] == $past(frame[8])));

    // R3: non-configuration broadcasts are accepted at once
    p_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame[15:9] == 7'h7F &&
         !(frame[8] && frame[7:0] >= 8'd32 && frame[7:0] <= 8'd128))
        |=> acc_valid);

    // R1: an unprogrammed slave ignores every short address
    p_unprog_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame[15] && own_short == 8'hFF) |=> !acc_valid);

    // R4: special commands are accepted with their index
    p_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame[8] && (frame[15:13] == 3'b101 || frame[15:13] == 3'b110))
        |=> (acc_valid && acc_kind == 2'd2 && acc_spc == {$past(frame[14]), $past(frame[12:9])}));

    // R4: reserved 111 codes other than broadcast are dropped
    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame[15:13] == 3'b111 && frame[15:9] != 7'h7F) |=> !acc_valid);

endmodule

bind dali_cmd_gate dali_cmd_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame       (frame),
    .own_short   (own_short),
    .acc_valid   (acc_valid),
    .acc_kind    (acc_kind),
    .acc_spc     (acc_spc)
);

// File: tb/dali_cmd_gate_bench.sv
module dali_cmd_gate_bench;

    localparam int unsigned WIN = 100;
    localparam int          NV  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [15:0] frame = '0;
    logic        ms_tick = 1'b0;
    logic [7:0]  own_short = 8'h05;
    logic [15:0] group_mask = 16'h0009;
    logic        acc_valid;
    logic [7:0]  acc_data;
    logic [1:0]  acc_kind;
    logic [4:0]  acc_spc;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dali_cmd_gate #(.WINDOW_MS(WIN)) u_dali_cmd_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame       (frame),
        .ms_tick     (ms_tick),
        .own_short   (own_short),
        .group_mask  (group_mask),
        .acc_valid   (acc_valid),
        .acc_data    (acc_data),
        .acc_kind    (acc_kind),
        .acc_spc     (acc_spc)
    );

    // {frame, exp_acc, exp_kind, exp_data, exp_spc, req number}; own 5, groups 0 and 3
    localparam logic [38:0] VEC [NV] = '{
        {16'h0A80, 1'b1, 2'd0, 8'h80, 5'd0,  7'd1},  // R1 R5 short 5 level
        {16'h0B05, 1'b1, 2'd1, 8'h05, 5'd0,  7'd5},  // R5 short 5 command
        {16'h0C80, 1'b0, 2'd0, 8'h00, 5'd0,  7'd1},  // R1 short 6 not ours
        {16'h8680, 1'b1, 2'd0, 8'h80, 5'd0,  7'd2},  // R2 group 3
        {16'h8481, 1'b0, 2'd0, 8'h00, 5'd0,  7'd2},  // R2 group 2 not member
        {16'h8101, 1'b1, 2'd1, 8'h01, 5'd0,  7'd2},  // R2 group 0 command
        {16'hFEFE, 1'b1, 2'd0, 8'hFE, 5'd0,  7'd3},  // R3 broadcast level
        {16'hFF00, 1'b1, 2'd1, 8'h00, 5'd0,  7'd3},  // R3 broadcast command
        {16'hA500, 1'b1, 2'd2, 8'h00, 5'd2,  7'd4},  // R4 special index 2
        {16'hC3AA, 1'b1, 2'd2, 8'hAA, 5'd17, 7'd4},  // R4 special index 17
        {16'hA400, 1'b0, 2'd0, 8'h00, 5'd0,  7'd4},  // R4 special pattern, bit0 clear
        {16'hE100, 1'b0, 2'd0, 8'h00, 5'd0,  7'd4},  // R4 reserved 1110
        {16'hFB00, 1'b0, 2'd0, 8'h00, 5'd0,  7'd4},  // R4 reserved 11111011
        {16'h0B81, 1'b1, 2'd1, 8'h81, 5'd0,  7'd10}, // R10 command 129
        {16'h0B1F, 1'b1, 2'd1, 8'h1F, 5'd0,  7'd10}  // R10 command 31
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] f);
        @(negedge clk);
        frame_valid = 1'b1;
        frame       = f;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic expect_acc(input string req, input logic exp, input logic [7:0] d);
        check(acc_valid == exp, req, "acc_valid", 32'(acc_valid), 32'(exp));
        if (exp) check(acc_data == d, req, "acc_data", 32'(acc_data), 32'(d));
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        check(acc_valid == 1'b0, "R11", "acc_valid after reset", 32'(acc_valid), 0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][38:23]);
            check(acc_valid == VEC[i][22], $sformatf("R%0d", VEC[i][6:0]),
                  $sformatf("vec %0d acc_valid", i), 32'(acc_valid), 32'(VEC[i][22]));
            if (VEC[i][22]) begin
                check(acc_kind == VEC[i][21:20], $sformatf("R%0d", VEC[i][6:0]),
                      $sformatf("vec %0d kind", i), 32'(acc_kind), 32'(VEC[i][21:20]));
                check(acc_data == VEC[i][19:12], $sformatf("R%0d", VEC[i][6:0]),
                      $sformatf("vec %0d data", i), 32'(acc_data), 32'(VEC[i][19:12]));
                if (VEC[i][21:20] == 2'd2)
                    check(acc_spc == VEC[i][11:7], "R4", $sformatf("vec %0d spc", i),
                          32'(acc_spc), 32'(VEC[i][11:7]));
            end
        end

        // R6: no strobe, no accept; frame changes alone do nothing
        @(negedge clk);
        frame = 16'hFF05;
        repeat (3) @(negedge clk);
        check(acc_valid == 1'b0, "R6", "idle acc_valid", 32'(acc_valid), 0);
        send(16'hFF05);
        expect_acc("R6", 1'b1, 8'h05);
        @(negedge clk);
        check(acc_valid == 1'b0, "R6", "pulse width", 32'(acc_valid), 0);

        // R7: configuration pair, lower and upper bound
        send(16'h0B20);
        expect_acc("R7", 1'b0, 8'h00);
        send(16'h0B20);
        expect_acc("R7", 1'b1, 8'h20);
        send(16'hFF80);
        expect_acc("R7", 1'b0, 8'h00);
        ticks(WIN - 1);
        send(16'hFF80);
        expect_acc("R7", 1'b1, 8'h80);
        // R7: configuration for another slave never accepted
        send(16'h0D2A);
        expect_acc("R7", 1'b0, 8'h00);
        send(16'h0D2A);
        expect_acc("R7", 1'b0, 8'h00);

        // R8: window expired, late copy becomes new first
        send(16'h0B2A);
        ticks(WIN);
        send(16'h0B2A);
        expect_acc("R8", 1'b0, 8'h00);
        send(16'h0B2A);
        expect_acc("R8", 1'b1, 8'h2A);

        // R9: a different frame in between cancels
        send(16'h0B2B);
        send(16'h0B05);
        expect_acc("R9", 1'b1, 8'h05);
        send(16'h0B2B);
        expect_acc("R9", 1'b0, 8'h00);

        // R11: reset discards a pending configuration frame
        send(16'h0B2C);
        do_reset();
        send(16'h0B2C);
        expect_acc("R11", 1'b0, 8'h00);

        // R1: unprogrammed slave
        own_short = 8'hFF;
        send(16'h7E10);
        expect_acc("R1", 1'b0, 8'h00);
        send(16'h0A10);
        expect_acc("R1", 1'b0, 8'h00);
        send(16'hFE33);
        expect_acc("R1", 1'b1, 8'h33);
        send(16'h8044);
        expect_acc("R1", 1'b1, 8'h44);
        own_short = 8'h3F;
        send(16'h7E10);
        expect_acc("R1", 1'b1, 8'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule